// File: doc/BRIEF.md
# Temperature Sensor Register Target on SMBus

This block is the two-wire serial target of a three-channel temperature sensor. It oversamples the clock and data lines on the system clock, finds start and stop conditions, answers its own 7-bit device address, and gives the bus master byte access to a small register file. The first byte written after the address is a command byte. It sets a register pointer, and later data bytes and reads use that pointer. Temperature readings, alarm flags and a busy flag arrive on parallel input ports. The configuration byte and a one-shot conversion strobe leave on output ports.

A start condition seen at any moment aborts whatever transfer is in progress. This includes a start in the middle of a byte or while the target holds the data line. Each line also has its own low-time watchdog. If either line stays low longer than `TIMEOUT_CYC` system clocks, the engine drops back to idle and lets go of the data line. A read transaction copies the temperature inputs into a shadow set at its address byte. This keeps the high and low halves of a reading from mixing two conversions.

Top module: `smb_sensor_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal `DEV_ADDR`, and it acknowledges every data byte written to it. An address byte with any other value gets no acknowledge, and the target stays silent until the next start.
- R2: The first byte after a write address loads the register pointer. A read returns the register the pointer selects: 02h status, 03h configuration, 0Fh one-shot, 10h/11h/12h local/remote-1/remote-2 temperature high byte, 20h/21h/22h the matching low bytes, FEh maker code (`MFR_ID`, default 01h), FFh revision code (`REV_ID`, default 61h).
- R3: The status byte carries `busy_i` in bit 7 and `alarm_i` in bits 1:0. The local low byte shows only bits 7:6 of its input, and the remote low bytes show only bits 7:5. Every other bit of these registers reads 0.
- R4: A byte written to 03h is stored ANDed with `CFG_MASK` (default 47h), and the stored value is driven on `cfg_o`. A read of 03h returns the stored value. `cfg_o` changes only while SCL is high.
- R5: A data byte written to 0Fh raises `one_shot_o` for exactly one clock, but only when bit `STBY_BIT` (default 6, 1 = standby) of the configuration is 1. The byte itself is not kept, and reads of 0Fh return 00h.
- R6: Writes to the status, temperature and ID registers, and to any unmapped pointer, are acknowledged and change nothing. Reads of unmapped pointers return 00h.
- R7: A start condition inside a byte, including one made while the target is sending, aborts the transfer. The next byte is then taken as an address.
- R8: When SCL or SDA has been low for more than `TIMEOUT_CYC` clocks, the target returns to idle and releases SDA. It does not release SDA before that limit.
- R9: The six temperature inputs are captured when a read address is acknowledged. Every byte of that read transaction comes from this capture.
- R10: After the master answers a read byte with a not-acknowledge, the target keeps SDA released until a stop or a start.
- R11: After reset, `sda_oe` is 0, `cfg_o` is 00h and `one_shot_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| loc_hi_i | input | 8 | Local temperature, high byte |
| loc_lo_i | input | 8 | Local temperature, low byte |
| rem1_hi_i | input | 8 | Remote channel 1 temperature, high byte |
| rem1_lo_i | input | 8 | Remote channel 1 temperature, low byte |
| rem2_hi_i | input | 8 | Remote channel 2 temperature, high byte |
| rem2_lo_i | input | 8 | Remote channel 2 temperature, low byte |
| alarm_i | input | 2 | Status flags shown in status bits 1:0 |
| busy_i | input | 1 | Conversion busy flag shown in status bit 7 |
| cfg_o | output | 8 | Stored configuration byte |
| one_shot_o | output | 1 | Single-clock conversion request |

## Verification
The hardest case to reach is a start condition made while the target owns the data line. A master cannot raise SDA while the target holds it low. The bench therefore reads the revision register, whose top bit is 0 and next bit is 1, and takes exactly one bit. The target then has SDA released for bit 6, and the bench issues the repeated start in that window. The timeout is reached by reading a register whose first bit is 0 and then freezing SCL low while the target pulls SDA down. The bench checks that SDA is still held partway through the limit and released after it.

// File: rtl/smb_sensor_target.sv
module smb_sensor_target #(
  parameter logic [6:0]  DEV_ADDR    = 7'h2B,
  parameter int unsigned TIMEOUT_CYC = 3_000_000,
  parameter logic [7:0]  MFR_ID      = 8'h01,
  parameter logic [7:0]  REV_ID      = 8'h61,
  parameter logic [7:0]  CFG_MASK    = 8'h47,
  parameter int unsigned STBY_BIT    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] loc_hi_i,
  input  logic [7:0] loc_lo_i,
  input  logic [7:0] rem1_hi_i,
  input  logic [7:0] rem1_lo_i,
  input  logic [7:0] rem2_hi_i,
  input  logic [7:0] rem2_lo_i,
  input  logic [1:0] alarm_i,
  input  logic       busy_i,
  output logic [7:0] cfg_o,
  output logic       one_shot_o
);

  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_CYC);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_WR, S_RD, S_MACK, S_RELOAD} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [TW-1:0] tc_scl, tc_sda;
  logic [3:0] cnt;
  logic [7:0] sh, ptr, rd_val;
  logic       rw, first, ackph;
  logic [7:0] shd [6];

  wire s_scl = scl_q[1];
  wire p_scl = scl_q[2];
  wire s_sda = sda_q[1];
  wire p_sda = sda_q[2];

  wire rise  = s_scl & ~p_scl;
  wire fall  = ~s_scl & p_scl;
  wire start = s_scl & p_scl & p_sda & ~s_sda;
  wire stop  = s_scl & p_scl & ~p_sda & s_sda;
  wire tout  = (tc_scl == TLIM) || (tc_sda == TLIM);
  wire [7:0] rx = {sh[6:0], s_sda};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_scl <= '0;
      tc_sda <= '0;
    end else begin
      if (s_scl) tc_scl <= '0;
      else if (tc_scl != TLIM) tc_scl <= tc_scl + 1'b1;
      if (s_sda) tc_sda <= '0;
      else if (tc_sda != TLIM) tc_sda <= tc_sda + 1'b1;
    end
  end

  always_comb begin
    case (ptr)
      8'h02:   rd_val = {busy_i, 5'b0, alarm_i};
      8'h03:   rd_val = cfg_o;
      8'h10:   rd_val = shd[0];
      8'h11:   rd_val = shd[2];
      8'h12:   rd_val = shd[4];
      8'h20:   rd_val = shd[1] & 8'hC0;
      8'h21:   rd_val = shd[3] & 8'hE0;
      8'h22:   rd_val = shd[5] & 8'hE0;
      8'hFE:   rd_val = MFR_ID;
      8'hFF:   rd_val = REV_ID;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      ptr        <= '0;
      rw         <= 1'b0;
      first      <= 1'b0;
      ackph      <= 1'b0;
      sda_oe     <= 1'b0;
      cfg_o      <= '0;
      one_shot_o <= 1'b0;
      for (int i = 0; i < 6; i++) shd[i] <= '0;
    end else begin
      one_shot_o <= 1'b0;
      if (tout) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start) begin
        st     <= S_ADDR;
        cnt    <= '0;
        ackph  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR: if (rise) begin
            sh  <= rx;
            cnt <= cnt + 1'b1;
            if (cnt == 4'd7) begin
              if (sh[6:0] == DEV_ADDR) begin
                st    <= S_ACK;
                rw    <= s_sda;
                first <= 1'b1;
                if (s_sda) begin
                  shd[0] <= loc_hi_i;  shd[1] <= loc_lo_i;
                  shd[2] <= rem1_hi_i; shd[3] <= rem1_lo_i;
                  shd[4] <= rem2_hi_i; shd[5] <= rem2_lo_i;
                end
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_WR: if (rise) begin
            sh  <= rx;
            cnt <= cnt + 1'b1;
            if (cnt == 4'd7) begin
              if (first) ptr <= rx;
              else if (ptr == 8'h03) cfg_o <= rx & CFG_MASK;
              else if (ptr == 8'h0F && cfg_o[STBY_BIT]) one_shot_o <= 1'b1;
              first <= 1'b0;
              st    <= S_ACK;
            end
          end
          S_ACK: if (fall) begin
            if (!ackph) begin
              sda_oe <= 1'b1;
              ackph  <= 1'b1;
            end else begin
              ackph <= 1'b0;
              cnt   <= '0;
              if (rw) begin
                sda_oe <= ~rd_val[7];
                sh     <= {rd_val[6:0], 1'b0};
                st     <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WR;
              end
            end
          end
          S_RD: begin
            if (rise) cnt <= cnt + 1'b1;
            else if (fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sda_oe <= ~sh[7];
                sh     <= {sh[6:0], 1'b0};
              end
            end
          end
          S_MACK: if (rise) st <= s_sda ? S_IDLE : S_RELOAD;
          S_RELOAD: if (fall) begin
            cnt    <= '0;
            sda_oe <= ~rd_val[7];
            sh     <= {rd_val[6:0], 1'b0};
            st     <= S_RD;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_sensor_target_chk.sv
module smb_sensor_target_chk #(
  parameter int unsigned TIMEOUT_CYC = 3_000_000,
  parameter int unsigned STBY_BIT    = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe,
  input logic [7:0] cfg_o,
  input logic       one_shot_o
);

  localparam logic [31:0] LIM = 32'(TIMEOUT_CYC) + 32'd6;

  logic [31:0] lo_scl, lo_sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_scl <= '0;
      lo_sda <= '0;
    end else begin
      if (scl_i) lo_scl <= '0;
      else if (lo_scl <= LIM) lo_scl <= lo_scl + 1;
      if (sda_i) lo_sda <= '0;
      else if (lo_sda <= LIM) lo_sda <= lo_sda + 1;
    end
  end

  a_r11_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!sda_oe && cfg_o == 8'h00 && !one_shot_o));

  a_r5_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    one_shot_o |=> !one_shot_o);

  a_r5_strobe_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    one_shot_o |-> cfg_o[STBY_BIT]);

  a_r4_cfg_moves_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> (scl_i && $past(scl_i)));

  a_r1_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r10_release_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);

  a_r8_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_scl > LIM || lo_sda > LIM) |-> !sda_oe);

endmodule

bind smb_sensor_target smb_sensor_target_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .STBY_BIT(STBY_BIT)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .scl_i(scl_i),
  .sda_i(sda_i),
  .sda_oe(sda_oe),
  .cfg_o(cfg_o),
  .one_shot_o(one_shot_o)
);

// File: tb/test_smb_sensor_target.sv
module test_smb_sensor_target;
  localparam int Q = 4;
  localparam int TMO = 400;
  localparam logic [6:0] ADR = 7'h2B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [7:0] loc_hi = 8'h19, loc_lo = 8'hFF, r1_hi = 8'h55, r1_lo = 8'hFF;
  logic [7:0] r2_hi = 8'hAA, r2_lo = 8'h3F;
  logic [1:0] alarm = 2'b10;
  logic busy = 1'b1;
  logic sda_oe, one_shot;
  logic [7:0] cfg;
  logic sda_line;
  int nchk = 0, nfail = 0, pulses = 0;
  logic last_ack;
  bit done = 0;

  assign sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  smb_sensor_target #(.TIMEOUT_CYC(TMO)) i_smb_sensor_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .loc_hi_i(loc_hi), .loc_lo_i(loc_lo), .rem1_hi_i(r1_hi), .rem1_lo_i(r1_lo),
    .rem2_hi_i(r2_hi), .rem2_lo_i(r2_lo), .alarm_i(alarm), .busy_i(busy),
    .cfg_o(cfg), .one_shot_o(one_shot));

  always @(posedge clk) if (one_shot) pulses <= pulses + 1;

  localparam logic [15:0] VEC [12] = '{
    {8'h02, 8'h82}, {8'h03, 8'h00}, {8'h0F, 8'h00}, {8'h10, 8'h19},
    {8'h11, 8'h55}, {8'h12, 8'hAA}, {8'h20, 8'hC0}, {8'h21, 8'hE0},
    {8'h22, 8'h20}, {8'hFE, 8'h01}, {8'hFF, 8'h61}, {8'h05, 8'h00}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda = 1; m_scl = 1; wq(1); m_sda = 0; wq(2); m_scl = 0; wq(1);
  endtask

  task automatic m_rstart;
    m_sda = 1; wq(1); m_scl = 1; wq(2); m_sda = 0; wq(2); m_scl = 0; wq(1);
  endtask

  task automatic m_stop;
    m_sda = 0; wq(1); m_scl = 1; wq(2); m_sda = 1; wq(2);
  endtask

  task automatic wbit(input logic b);
    m_sda = b; wq(1); m_scl = 1; wq(2); m_scl = 0; wq(1);
  endtask

  task automatic rbit(output logic b);
    m_sda = 1; wq(1); m_scl = 1; wq(1); b = sda_line; wq(1); m_scl = 0; wq(1);
  endtask

  task automatic wbyte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(last_ack);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(nack);
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] v);
    m_start; wbyte({ADR, 1'b0}); wbyte(p); wbyte(v); m_stop;
  endtask

  task automatic rd_reg(input logic [7:0] p, output logic [7:0] d);
    m_start; wbyte({ADR, 1'b0}); wbyte(p);
    m_rstart; wbyte({ADR, 1'b1}); rbyte(d, 1'b1); m_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic b;
    int p0;
    repeat (4) @(negedge clk);
    chk("R11 oe", sda_oe, 0);
    chk("R11 cfg", cfg, 8'h00);
    chk("R11 strobe", one_shot, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    m_start; wbyte({7'h2C, 1'b0});
    chk("R1 foreign address not acked", last_ack, 1);
    m_stop;
    m_start; wbyte({ADR, 1'b0});
    chk("R1 own address acked", last_ack, 0);
    wbyte(8'h05);
    chk("R1 data byte acked", last_ack, 0);
    m_stop;

    foreach (VEC[k]) begin
      rd_reg(VEC[k][15:8], d);
      chk($sformatf("R2/R3 read %0h", VEC[k][15:8]), d, VEC[k][7:0]);
    end

    wr_reg(8'h03, 8'hFF);
    chk("R4 cfg_o masked", cfg, 8'h47);
    rd_reg(8'h03, d);
    chk("R4 cfg readback", d, 8'h47);

    p0 = pulses;
    wr_reg(8'h0F, 8'hA5);
    chk("R5 strobe in standby", pulses - p0, 1);
    rd_reg(8'h0F, d);
    chk("R5 one-shot reads zero", d, 8'h00);
    wr_reg(8'h03, 8'h00);
    p0 = pulses;
    wr_reg(8'h0F, 8'hA5);
    chk("R5 no strobe when running", pulses - p0, 0);

    wr_reg(8'h10, 8'h00);
    rd_reg(8'h10, d);
    chk("R6 temp read-only", d, 8'h19);
    wr_reg(8'h02, 8'h00);
    rd_reg(8'h02, d);
    chk("R6 status read-only", d, 8'h82);
    m_start; wbyte({ADR, 1'b0}); wbyte(8'h05); wbyte(8'h77);
    chk("R6 unmapped write acked", last_ack, 0);
    m_stop;
    rd_reg(8'h05, d);
    chk("R6 unmapped reads zero", d, 8'h00);

    m_start; wbyte({ADR, 1'b0}); wbyte(8'h10);
    m_rstart; wbyte({ADR, 1'b1});
    rbyte(d, 1'b0);
    loc_hi = 8'h7E;
    rbyte(d2, 1'b1);
    m_stop;
    chk("R9 first byte", d, 8'h19);
    chk("R9 second byte from capture", d2, 8'h19);
    rd_reg(8'h10, d);
    chk("R9 new capture", d, 8'h7E);

    rd_reg(8'h0F, d);
    m_start; wbyte({ADR, 1'b0}); wbyte(8'h0F);
    m_rstart; wbyte({ADR, 1'b1}); rbyte(d, 1'b1);
    rbit(b);
    chk("R10 released after nack", b, 1);
    chk("R10 oe low", sda_oe, 0);
    m_stop;

    m_start; wbyte({ADR, 1'b0});
    wbit(0); wbit(1); wbit(0); wbit(0);
    m_rstart; wbyte({ADR, 1'b0}); wbyte(8'h03); wbyte(8'h40); m_stop;
    chk("R7 abort mid-write byte", cfg, 8'h40);
    m_start; wbyte({ADR, 1'b0}); wbyte(8'hFF);
    m_rstart; wbyte({ADR, 1'b1});
    rbit(b);
    chk("R7 target was sending", b, 0);
    m_rstart; wbyte({ADR, 1'b0}); wbyte(8'h03); wbyte(8'h00); m_stop;
    chk("R7 abort during read", cfg, 8'h00);

    m_start; wbyte({ADR, 1'b0}); wbyte(8'hFE);
    m_rstart; wbyte({ADR, 1'b1});
    repeat (200) @(negedge clk);
    chk("R8 still holding before limit", sda_oe, 1);
    repeat (300) @(negedge clk);
    chk("R8 released after limit", sda_oe, 0);
    m_sda = 1; m_scl = 1; wq(2);
    rd_reg(8'hFF, d);
    chk("R8 usable after timeout", d, 8'h61);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule